// File: doc/BRIEF.md
# Local-Side Write Burst Sequencer for a PCI Master Core

This block sits on the user side of a PCI master core and drives the two shared local buses the core reads from: a 64-bit multiplexed address/data bus and an 8-bit command/byte-enable bus. User logic loads the write words, each with its byte enables, into a small internal queue. It then issues one request with an address, a bus command, an addressing width, a data width, a byte-enable mode and a burst length. The sequencer places the address and command on the buses and holds them until the core's active-low address acknowledge arrives. For 64-bit addressing it runs the dual-address-cycle split. In the next phase it presents byte enables, then streams the queued words, one for each data acknowledge from the core.

Every output comes from registered state. When the core stalls, the buses keep their values until the core's strobe moves the sequence on. A 32-bit data request uses only the low halves of both buses. A request in fixed byte-enable mode applies the first word's enables to the whole burst. A request in variable mode gives each word its own enables.

Top module: `lm_req_seq`

## Requirements
- R1: While `rst_ni` is low and after reset, `busy_o` and `done_o` are 0 and `ad_o` and `cbe_o` are all zeros.
- R2: From the cycle after `start_i` is accepted until the cycle in which `adr_ack_ni` is low, `ad_o` holds the request address. With 32-bit addressing (`req_addr64_i`=0), bits 63:32 of `ad_o` are forced to zero.
- R3: With 32-bit addressing, `cbe_o[3:0]` carries the request command unchanged in PCI command encoding during the address phase, and `cbe_o[7:4]` is zero.
- R4: With 64-bit addressing, `cbe_o` is {command, 4'b1101} during the address phase. After the acknowledge it keeps that value and the full address for as long as `addr_hi_phase_i` is 1, and for one more cycle in which it reads 0.
- R5: In the cycle right after the address acknowledge (or after the dual-address phase ends), `cbe_o` carries the first queued word's byte enables and `ad_o` is zero.
- R6: In the data phase, `ad_o` shows the oldest queued word. It stays stable while `data_ack_ni` is high and moves to the next word after a cycle with `data_ack_ni` low.
- R7: With `req_var_be_i`=0, `cbe_o` keeps the first word's byte enables for every data cycle of the burst. The byte enables stored with later words have no effect.
- R8: With `req_var_be_i`=1, `cbe_o` in each data cycle carries the byte enables queued with the word currently on `ad_o`.
- R9: With `req_wide_i`=0, `ad_o[63:32]` and `cbe_o[7:4]` are zero in the byte-enable and data phases. With `req_wide_i`=1, all 64 data bits and all 8 enable bits pass through.
- R10: A burst has `req_last_i`+1 words. `done_o` is high for exactly one cycle after the last word's acknowledge, and `busy_o` falls in the cycle after that. A `start_i` pulse while `busy_o` is 1 is ignored.
- R11: If the queue is empty when the byte-enable phase begins, the sequencer stays in that phase with `ad_o` and `cbe_o` at zero until a word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request issue pulse, taken when idle |
| req_addr_i | input | 64 | Request address |
| req_cmd_i | input | 4 | PCI bus command |
| req_addr64_i | input | 1 | 1 selects 64-bit (dual-cycle) addressing |
| req_wide_i | input | 1 | 1 selects a 64-bit data path for the request |
| req_var_be_i | input | 1 | 1 selects per-word byte enables |
| req_last_i | input | 2 | Burst length minus one |
| busy_o | output | 1 | A request is in progress |
| wr_push_i | input | 1 | Queue a write word |
| wr_data_i | input | 64 | Write word |
| wr_be_i | input | 8 | Byte enables for the word |
| wr_full_o | output | 1 | Queue full; pushes are dropped |
| adr_ack_ni | input | 1 | Core address acknowledge, active low |
| addr_hi_phase_i | input | 1 | Core transfer-state strobe for the second address phase |
| data_ack_ni | input | 1 | Core data acknowledge, active low |
| ad_o | output | 64 | Local address/data bus |
| cbe_o | output | 8 | Local command/byte-enable bus |
| done_o | output | 1 | One-cycle burst completion pulse |

## Verification
Two events can meet in one cycle: the core's address acknowledge, which must find the address already on the bus, and the switch of the same bus to byte enables on the next edge. On a 64-bit request, the dual-address strobe falling can also meet the byte-enable phase. The bench drives each core strobe after a random number of stall cycles. It checks `ad_o` and `cbe_o` in the acknowledge cycle itself and in the cycle after it, so an output that switches one cycle early or late is reported. A start pulse during an address stall and a byte-enable phase entered with an empty queue are also provoked. In both cases the bench checks that the buses are unchanged.

// File: rtl/lm_seq_pkg.sv
package lm_seq_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CBE_W  = 8;
  localparam int unsigned LEN_W  = 2;
  localparam logic [3:0]  CMD_DAC = 4'b1101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DAC_HI,
    ST_BE,
    ST_DATA,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [3:0]        cmd;
    logic              addr64;
    logic              wide;
    logic              var_be;
    logic [LEN_W-1:0]  last;
  } seq_req_t;
endpackage

// File: rtl/lm_seq_fifo.sv
module lm_seq_fifo #(
  parameter int unsigned W     = 72,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q[AW-1:0]] <= data_i;
        wr_q <= wr_q + 1'b1;
      end
      if (do_pop) rd_q <= rd_q + 1'b1;
    end
  end

  p_no_pop_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/lm_seq_ctrl.sv
module lm_seq_ctrl
  import lm_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  seq_req_t         req_i,
  input  logic             adr_ack_ni,
  input  logic             hi_phase_i,
  input  logic             data_ack_ni,
  input  logic             fifo_empty_i,
  input  logic [CBE_W-1:0] head_be_i,
  output seq_state_e       state_o,
  output seq_req_t         req_o,
  output logic [CBE_W-1:0] first_be_o,
  output logic             pop_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  seq_req_t         req_q;
  logic [LEN_W-1:0] cnt_q;
  logic [CBE_W-1:0] first_be_q;
  logic             last_word;

  assign pop_o     = (state_q == ST_DATA) && !data_ack_ni && !fifo_empty_i;
  assign last_word = (cnt_q == req_q.last);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_ADDR;
      ST_ADDR:   if (!adr_ack_ni) state_d = req_q.addr64 ? ST_DAC_HI : ST_BE;
      ST_DAC_HI: if (!hi_phase_i) state_d = ST_BE;
      ST_BE:     if (!fifo_empty_i) state_d = ST_DATA;
      ST_DATA:   if (pop_o && last_word) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_q      <= '0;
      cnt_q      <= '0;
      first_be_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        req_q <= req_i;
        cnt_q <= '0;
      end
      if (state_q == ST_BE && !fifo_empty_i) first_be_q <= head_be_i;
      if (pop_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o    = state_q;
  assign req_o      = req_q;
  assign first_be_o = first_be_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  p_be_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && !adr_ack_ni && !req_q.addr64) |=> (state_q == ST_BE));
  p_req_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(req_q));
endmodule

// File: rtl/lm_seq_mux.sv
module lm_seq_mux
  import lm_seq_pkg::*;
(
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        cmd_i,
  input  logic              addr64_i,
  input  logic              wide_i,
  input  logic              var_be_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic [CBE_W-1:0]  head_be_i,
  input  logic [CBE_W-1:0]  first_be_i,
  output logic [DATA_W-1:0] ad_o,
  output logic [CBE_W-1:0]  cbe_o
);
  localparam int unsigned DH = DATA_W / 2;
  localparam int unsigned BH = CBE_W / 2;

  logic [DATA_W-1:0] data_fit;
  logic [CBE_W-1:0]  be_sel, be_fit, head_be_fit;

  assign be_sel      = var_be_i ? head_be_i : first_be_i;
  assign data_fit    = wide_i ? head_data_i : {{DH{1'b0}}, head_data_i[DH-1:0]};
  assign be_fit      = wide_i ? be_sel : {{BH{1'b0}}, be_sel[BH-1:0]};
  assign head_be_fit = wide_i ? head_be_i : {{BH{1'b0}}, head_be_i[BH-1:0]};

  always_comb begin
    ad_o  = '0;
    cbe_o = '0;
    unique case (state_i)
      ST_ADDR, ST_DAC_HI: begin
        ad_o  = addr64_i ? addr_i : {{(ADDR_W-32){1'b0}}, addr_i[31:0]};
        cbe_o = addr64_i ? {cmd_i, CMD_DAC} : {4'b0000, cmd_i};
      end
      ST_BE:   if (!empty_i) cbe_o = head_be_fit;
      ST_DATA: if (!empty_i) begin
        ad_o  = data_fit;
        cbe_o = be_fit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lm_req_seq.sv
module lm_req_seq
  import lm_seq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       req_addr_i,
  input  logic [3:0]        req_cmd_i,
  input  logic              req_addr64_i,
  input  logic              req_wide_i,
  input  logic              req_var_be_i,
  input  logic [LEN_W-1:0]  req_last_i,
  output logic              busy_o,
  input  logic              wr_push_i,
  input  logic [63:0]       wr_data_i,
  input  logic [7:0]        wr_be_i,
  output logic              wr_full_o,
  input  logic              adr_ack_ni,
  input  logic              addr_hi_phase_i,
  input  logic              data_ack_ni,
  output logic [63:0]       ad_o,
  output logic [7:0]        cbe_o,
  output logic              done_o
);
  localparam int unsigned QW = DATA_W + CBE_W;

  seq_state_e       state;
  seq_req_t         req_in, req_q;
  logic [QW-1:0]    head;
  logic             fifo_empty, pop;
  logic [CBE_W-1:0] first_be;

  assign req_in = '{addr: req_addr_i, cmd: req_cmd_i, addr64: req_addr64_i,
                    wide: req_wide_i, var_be: req_var_be_i, last: req_last_i};

  lm_seq_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_push_i),
    .data_i  ({wr_data_i, wr_be_i}),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (fifo_empty),
    .full_o  (wr_full_o)
  );

  lm_seq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .req_i        (req_in),
    .adr_ack_ni   (adr_ack_ni),
    .hi_phase_i   (addr_hi_phase_i),
    .data_ack_ni  (data_ack_ni),
    .fifo_empty_i (fifo_empty),
    .head_be_i    (head[CBE_W-1:0]),
    .state_o      (state),
    .req_o        (req_q),
    .first_be_o   (first_be),
    .pop_o        (pop),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  lm_seq_mux u_mux (
    .state_i     (state),
    .addr_i      (req_q.addr),
    .cmd_i       (req_q.cmd),
    .addr64_i    (req_q.addr64),
    .wide_i      (req_q.wide),
    .var_be_i    (req_q.var_be),
    .empty_i     (fifo_empty),
    .head_data_i (head[QW-1:CBE_W]),
    .head_be_i   (head[CBE_W-1:0]),
    .first_be_i  (first_be),
    .ad_o        (ad_o),
    .cbe_o       (cbe_o)
  );

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ADDR && adr_ack_ni) |=> ($stable(ad_o) && $stable(cbe_o)));
  p_dac_low_nibble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_ADDR || state == ST_DAC_HI) && req_q.addr64) |-> (cbe_o[3:0] == CMD_DAC));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && data_ack_ni && !fifo_empty) |=> ($stable(ad_o) && $stable(cbe_o)));
  p_fixed_be_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && $past(state) == ST_DATA && !req_q.var_be && !fifo_empty)
      |-> $stable(cbe_o));
  p_narrow_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_DATA || state == ST_BE) && !req_q.wide)
      |-> (ad_o[63:32] == '0 && cbe_o[7:4] == '0));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ad_o == '0 && cbe_o == '0 && !done_o));
endmodule

// File: tb/lm_req_seq_tb_top.sv
module lm_req_seq_tb_top;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [63:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        req_a64 = 1'b0, req_wide = 1'b0, req_vb = 1'b0;
  logic [1:0]  req_last = '0;
  logic        busy, full, done;
  logic        push = 1'b0;
  logic [63:0] wdata = '0;
  logic [7:0]  wbe = '0;
  logic        adr_ack_n = 1'b1, hi_ph = 1'b0, dat_ack_n = 1'b1;
  logic [63:0] ad;
  logic [7:0]  cbe;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lm_req_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .req_addr_i(req_addr),
    .req_cmd_i(req_cmd), .req_addr64_i(req_a64), .req_wide_i(req_wide),
    .req_var_be_i(req_vb), .req_last_i(req_last), .busy_o(busy),
    .wr_push_i(push), .wr_data_i(wdata), .wr_be_i(wbe), .wr_full_o(full),
    .adr_ack_ni(adr_ack_n), .addr_hi_phase_i(hi_ph), .data_ack_ni(dat_ack_n),
    .ad_o(ad), .cbe_o(cbe), .done_o(done)
  );

  // {addr64, wide, var_be, last[1:0], cmd[3:0], addr[63:0]}
  localparam logic [72:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 2'd3, 4'h7, 64'h0000_0000_1234_5678},
    {1'b1, 1'b1, 1'b0, 2'd2, 4'h7, 64'h0000_0001_8000_0010},
    {1'b0, 1'b1, 1'b1, 2'd3, 4'h7, 64'hDEAD_BEEF_0000_1000},
    {1'b1, 1'b0, 1'b1, 2'd1, 4'hF, 64'h0000_00A5_0000_0040},
    {1'b0, 1'b0, 1'b1, 2'd0, 4'h3, 64'h0000_0000_0000_0CF8},
    {1'b1, 1'b1, 1'b1, 2'd3, 4'h7, 64'h7777_0000_0000_0100}
  };

  function automatic logic [63:0] wd(int idx, int w);
    return {8'hA0 + 8'(idx), 24'(w), 8'h50 + 8'(idx), 24'(w) * 24'h111};
  endfunction

  function automatic logic [7:0] wb(int idx, int w);
    return 8'h3C ^ 8'(idx * 16 + w * 5 + 1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input int idx, input logic a64, input logic wide, input logic vb,
                         input logic [1:0] last, input logic [3:0] cmd,
                         input logic [63:0] addr, input bit late, input bit poke);
    int ast = poke ? 2 : $urandom_range(0, 2);
    logic [63:0] ea  = a64 ? addr : {32'h0, addr[31:0]};
    logic [7:0]  ecb = a64 ? {cmd, 4'hD} : {4'h0, cmd};
    if (!late) begin
      for (int w = 0; w <= int'(last); w++) begin
        @(negedge clk); push = 1'b1; wdata = wd(idx, w); wbe = wb(idx, w);
      end
    end
    @(negedge clk);
    push = 1'b0;
    start = 1'b1; req_addr = addr; req_cmd = cmd; req_a64 = a64;
    req_wide = wide; req_vb = vb; req_last = last;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < ast; s++) begin
      #1;
      check("R2 addr stall", ad, ea);
      check(a64 ? "R4 cmd stall" : "R3 cmd stall", 64'(cbe), 64'(ecb));
      check("R10 busy", 64'(busy), 64'd1);
      if (poke && s == 0) begin
        start = 1'b1; req_addr = ~addr; req_cmd = ~cmd;
      end
      @(negedge clk);
      start = 1'b0;
    end
    adr_ack_n = 1'b0;
    #1;
    check(poke ? "R10 start ignored addr" : "R2 addr at ack", ad, ea);
    check(a64 ? "R4 cmd at ack" : "R3 cmd at ack", 64'(cbe), 64'(ecb));
    @(negedge clk);
    adr_ack_n = 1'b1;
    if (a64) begin
      int hs = $urandom_range(1, 3);
      for (int h = 0; h < hs; h++) begin
        hi_ph = 1'b1; #1;
        check("R4 dac hi", 64'(cbe), 64'(ecb));
        check("R4 dac addr", ad, ea);
        @(negedge clk);
      end
      hi_ph = 1'b0; #1;
      check("R4 dac end", 64'(cbe), 64'(ecb));
      @(negedge clk);
    end
    if (late) begin
      for (int k = 0; k < 3; k++) begin
        #1;
        check("R11 empty ad", ad, 64'h0);
        check("R11 empty cbe", 64'(cbe), 64'h0);
        if (k == 2) begin
          push = 1'b1; wdata = wd(idx, 0); wbe = wb(idx, 0);
        end
        @(negedge clk);
        push = 1'b0;
      end
    end
    #1;
    check("R5 first be", 64'(cbe), 64'(wide ? wb(idx, 0) : {4'h0, wb(idx, 0)[3:0]}));
    check("R5 ad quiet", ad, 64'h0);
    @(negedge clk);
    for (int w = 0; w <= int'(last); w++) begin
      int ds = $urandom_range(0, 2);
      logic [7:0]  be = vb ? wb(idx, w) : wb(idx, 0);
      logic [7:0]  eb = wide ? be : {4'h0, be[3:0]};
      logic [63:0] ed = wide ? wd(idx, w) : {32'h0, wd(idx, w)[31:0]};
      for (int s = 0; s <= ds; s++) begin
        dat_ack_n = (s == ds) ? 1'b0 : 1'b1;
        #1;
        check("R6 R9 data", ad, ed);
        check(vb ? "R8 R9 var be" : "R7 R9 fixed be", 64'(cbe), 64'(eb));
        @(negedge clk);
      end
      dat_ack_n = 1'b1;
    end
    #1;
    check("R10 done pulse", 64'(done), 64'd1);
    @(negedge clk);
    #1;
    check("R10 done low", 64'(done), 64'd0);
    check("R10 idle", 64'(busy), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset ad", ad, 64'h0);
    check("R1 reset cbe", 64'(cbe), 64'h0);
    check("R1 reset done", 64'(done), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    check("R1 after release", 64'(busy), 64'd0);
    for (int i = 0; i < 6; i++) begin
      logic [72:0] v = VEC[i];
      run_txn(i, v[72], v[71], v[70], v[69:68], v[67:64], v[63:0], 1'b0, 1'b0);
    end
    run_txn(6, 1'b0, 1'b1, 1'b0, 2'd0, 4'h7, 64'h0000_0000_0000_2000, 1'b1, 1'b0);
    run_txn(7, 1'b0, 1'b0, 1'b0, 2'd1, 4'h7, 64'hCAFE_0000_4444_0000, 1'b0, 1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule